// File: doc/BRIEF.md
# Chainable Serial Command Word Receiver

This block is the serial front end of a digitally adjusted resistor. An active-low frame select opens a frame. While it is low, the serial data line is sampled on each rising edge of the serial clock and shifted into a word register, most significant bit first. When the frame select returns high, the block checks the frame length. If the frame carried a non-zero whole number of words, the block presents the most recently received word to the command decoder, together with a one-cycle valid pulse in the system clock domain.

The block also drives an open-drain serial output. Each bit pushed out of the word register appears there, so several devices can share one long frame in a chain. The command decoder can place a readback word into the block. That word then leaves on the serial output, most significant bit first, during the next frame only.

The serial clock may stop for any length of time within a frame. The serial clock must stay idle while the frame select is high. After the last serial clock edge of a frame, the frame select must stay low for at least SYNC_STAGES+2 system clock cycles. After it rises, it must stay high for at least SYNC_STAGES+4 system clock cycles.

Top module: `spi_chain_rx`

## Requirements
- R1: After reset, `word_vld` is 0, `word` is 0 and `sdo_drv_low` is 0, and the word register holds all zeros.
- R2: Bits enter MSB first. In a 16-bit frame, the first bit sent becomes `word[15]` and the last bit sent becomes `word[0]`.
- R3: `word_vld` pulses for exactly one system clock cycle, once per valid frame, only after `sync_n` has risen. A frame is valid only when its length is 16·k bits with k ≥ 1.
- R4: A frame of any other length produces no `word_vld` pulse, and `word` keeps its previous value. This includes 0, 15, 17, 31 and 33 bits.
- R5: In a frame of 32 or 48 bits, `word` equals the last 16 bits sent.
- R6: Pauses of any length between serial clock edges while `sync_n` is low do not change the received word or the output stream.
- R7: While `sync_n` is high, `sdo_drv_low` is 0 (output released). While `sync_n` is low, `sdo_drv_low` is 1 exactly when the current outgoing bit is 0.
- R8: Without a readback load, the outgoing bit before serial clock edge n (n counted from 1) is bit 16−n of the previous 16-bit register contents when n ≤ 16. When n > 16, it is the bit sent at edge n−16 of the current frame.
- R9: After a `rb_load` pulse, the next frame sends `rb_data` MSB first as its first 16 outgoing bits, followed by the bits of that frame. The frame after that sends the previous frame's bits again, as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is sampled on the rising edge |
| din | input | 1 | Serial data in |
| sdo_drv_low | output | 1 | Enable for the open-drain pull-down on the serial output; 0 releases the line to the external pull-up |
| rb_load | input | 1 | One-cycle strobe (clk domain) that arms a readback word for the next frame |
| rb_data | input | WORD_W | Readback word captured on `rb_load` |
| word_vld | output | 1 | One-cycle strobe: a valid frame has ended |
| word | output | WORD_W | Last complete word of the most recent valid frame |

## Verification
The checker watches properties that hold on every cycle:
- the valid strobe is a single-cycle pulse that appears only while the frame select is high;
- the delivered word never changes outside that pulse;
- the serial output is released whenever no frame is open.

Other behaviour only the bench's frame scenarios can show:
- the bit order;
- the rejection of lengths that are not whole words;
- the selection of the last word in long frames;
- immunity to clock pauses;
- the exact outgoing bit stream, including the one-frame life of a readback word.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

   // Width of a counter that indexes bit positions inside one word.
   function automatic int unsigned phase_width(input int unsigned word_w);
      return (word_w < 2) ? 1 : $clog2(word_w);
   endfunction

endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] ff;

   initial assert (STAGES >= 2) else $fatal(1, "spi_chain_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff[0] <= RST_VAL;
      else        ff[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff[s] <= RST_VAL;
         else        ff[s] <= ff[s-1];
      end
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter
   import spi_chain_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic              din,
   input  logic              rb_armed,
   input  logic [WORD_W-1:0] rb_word,
   output logic [WORD_W-1:0] shreg,
   output logic              word_done,
   output logic              sdo_bit
);

   localparam int unsigned       PH_W = phase_width(WORD_W);
   localparam logic [PH_W-1:0]   LAST = PH_W'(WORD_W - 1);

   logic [PH_W-1:0] phase;
   logic            started;
   logic            frame_clr;
   logic            use_rb;
   logic [WORD_W-1:0] shreg_nxt;

   initial assert (WORD_W >= 2) else $fatal(1, "spi_chain_shifter: WORD_W must be at least 2");

   // Frame state is cleared for as long as no frame is open.
   assign frame_clr = sync_n | ~rst_n;

   // Before the first edge of a frame an armed readback word owns the output.
   assign use_rb    = rb_armed & ~started;
   assign shreg_nxt = use_rb ? {rb_word[WORD_W-2:0], din} : {shreg[WORD_W-2:0], din};
   assign sdo_bit   = use_rb ? rb_word[WORD_W-1] : shreg[WORD_W-1];

   // Word register keeps its contents between frames.
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)       shreg <= '0;
      else if (!sync_n) shreg <= shreg_nxt;
   end

   always_ff @(posedge sclk or posedge frame_clr) begin
      if (frame_clr) begin
         phase     <= '0;
         started   <= 1'b0;
         word_done <= 1'b0;
      end else begin
         started   <= 1'b1;
         word_done <= (phase == LAST);
         phase     <= (phase == LAST) ? '0 : phase + 1'b1;
      end
   end

endmodule

// File: rtl/spi_chain_xfer.sv
module spi_chain_xfer #(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic              word_done,
   input  logic [WORD_W-1:0] shreg,
   input  logic              rb_load,
   input  logic [WORD_W-1:0] rb_data,
   output logic              word_vld,
   output logic [WORD_W-1:0] word,
   output logic              rb_armed,
   output logic [WORD_W-1:0] rb_word
);

   logic sync_s, sync_d;
   logic done_s, done_d;
   logic frame_end;

   spi_chain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(sync_n), .q(sync_s)
   );

   spi_chain_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d(word_done), .q(done_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_d <= 1'b1;
         done_d <= 1'b0;
      end else begin
         sync_d <= sync_s;
         done_d <= done_s;
      end
   end

   // The done flag and the frame select cross through equal-length chains;
   // done_d holds the flag as it was while the frame was still open.
   assign frame_end = sync_s & ~sync_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         word_vld <= frame_end & done_d;
         if (frame_end & done_d) word <= shreg;   // quiet while frame is closed
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_armed <= 1'b0;
         rb_word  <= '0;
      end else if (rb_load) begin
         rb_armed <= 1'b1;
         rb_word  <= rb_data;
      end else if (frame_end) begin
         rb_armed <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_chain_rx.sv
module spi_chain_rx #(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic              sclk,
   input  logic              din,
   output logic              sdo_drv_low,
   input  logic              rb_load,
   input  logic [WORD_W-1:0] rb_data,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);

   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] rb_word;
   logic              rb_armed;
   logic              word_done;
   logic              sdo_bit;

   spi_chain_shifter #(.WORD_W(WORD_W)) u_shift (
      .sclk     (sclk),
      .rst_n    (rst_n),
      .sync_n   (sync_n),
      .din      (din),
      .rb_armed (rb_armed),
      .rb_word  (rb_word),
      .shreg    (shreg),
      .word_done(word_done),
      .sdo_bit  (sdo_bit)
   );

   spi_chain_xfer #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_n   (sync_n),
      .word_done(word_done),
      .shreg    (shreg),
      .rb_load  (rb_load),
      .rb_data  (rb_data),
      .word_vld (word_vld),
      .word     (word),
      .rb_armed (rb_armed),
      .rb_word  (rb_word)
   );

   // Open drain: pull low only for a 0 bit inside an open frame.
   assign sdo_drv_low = ~sync_n & ~sdo_bit;

endmodule

// File: rtl/spi_chain_rx_chk.sv
module spi_chain_rx_chk #(
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_n,
   input logic              sdo_drv_low,
   input logic              word_vld,
   input logic [WORD_W-1:0] word
);

   AST_VLD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);                                   // R3

   AST_VLD_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> sync_n);                                      // R3

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word));                              // R4

   AST_SDO_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n |-> !sdo_drv_low);                                  // R7

endmodule

bind spi_chain_rx spi_chain_rx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_n     (sync_n),
   .sdo_drv_low(sdo_drv_low),
   .word_vld   (word_vld),
   .word       (word)
);

// File: tb/spi_chain_rx_tb.sv
module spi_chain_rx_tb;

   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sync_n = 1'b1;
   logic         sclk = 1'b0;
   logic         din = 1'b0;
   logic         rb_load = 1'b0;
   logic [W-1:0] rb_data = '0;
   logic         sdo_drv_low;
   logic         word_vld;
   logic [W-1:0] word;

   int n_chk = 0;
   int n_bad = 0;
   int vld_cnt = 0;
   logic [W-1:0] exp_sh = '0;
   int sdo_err = 0;

   spi_chain_rx #(.WORD_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
      .sdo_drv_low(sdo_drv_low), .rb_load(rb_load), .rb_data(rb_data),
      .word_vld(word_vld), .word(word)
   );

   always #5 clk = ~clk;

   always @(negedge clk) if (rst_n && word_vld) vld_cnt++;

   typedef struct packed {
      logic [31:0]  len;
      logic [63:0]  data;
      logic         gap;
      logic         exp_vld;
      logic [15:0]  exp_word;
   } vec_t;

   localparam int N_VEC = 10;
   localparam vec_t VECS [N_VEC] = '{
      '{32'd16, 64'h0000_0000_0000_A5C3, 1'b0, 1'b1, 16'hA5C3},
      '{32'd16, 64'h0000_0000_0000_0001, 1'b0, 1'b1, 16'h0001},
      '{32'd32, 64'h0000_0000_1234_BEEF, 1'b0, 1'b1, 16'hBEEF},
      '{32'd31, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0, 16'hBEEF},
      '{32'd33, 64'h0000_0001_5555_AAAA, 1'b0, 1'b0, 16'hBEEF},
      '{32'd15, 64'h0000_0000_0000_7ABC, 1'b0, 1'b0, 16'hBEEF},
      '{32'd0,  64'h0000_0000_0000_0000, 1'b0, 1'b0, 16'hBEEF},
      '{32'd16, 64'h0000_0000_0000_8000, 1'b1, 1'b1, 16'h8000},
      '{32'd48, 64'h0000_CAFE_F00D_1357, 1'b1, 1'b1, 16'h1357},
      '{32'd17, 64'h0000_0000_0001_FFFF, 1'b0, 1'b0, 16'h1357}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Sends one frame; checks the serial output before every edge (R7, R8, R9)
   // and release after the frame closes.
   task automatic send_frame(input int len, input logic [63:0] data, input bit gap,
                             input bit use_rb, input logic [W-1:0] rb_val);
      if (use_rb) exp_sh = rb_val;
      sdo_err = 0;
      vld_cnt = 0;
      sync_n = 1'b0;
      #20;
      for (int i = 0; i < len; i++) begin
         din = data[len-1-i];
         #10;
         if (sdo_drv_low !== ~exp_sh[W-1]) sdo_err++;
         sclk = 1'b1;
         exp_sh = {exp_sh[W-2:0], din};
         #20;
         sclk = 1'b0;
         #10;
         if (gap) #300;
      end
      #60;
      sync_n = 1'b1;
      #20;
      if (sdo_drv_low !== 1'b0) sdo_err++;
      #100;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #40;
      rst_n = 1'b1;
      #20;
      // R1 reset state
      check(word_vld === 1'b0, "R1 vld", 64'(word_vld), 0);
      check(word === '0, "R1 word", 64'(word), 0);
      check(sdo_drv_low === 1'b0, "R1 sdo", 64'(sdo_drv_low), 0);

      // Table walk: R2 order, R3/R4 length rule, R5 long frames, R6 pauses, R7/R8 stream
      for (int v = 0; v < N_VEC; v++) begin
         send_frame(int'(VECS[v].len), VECS[v].data, VECS[v].gap, 1'b0, '0);
         check(vld_cnt == (VECS[v].exp_vld ? 1 : 0), "R3/R4 strobe count",
               64'(vld_cnt), 64'(VECS[v].exp_vld));
         check(word === VECS[v].exp_word, "R2/R5/R6 word", 64'(word), 64'(VECS[v].exp_word));
         check(sdo_err == 0, "R7/R8 sdo stream", 64'(sdo_err), 0);
      end

      // R9 readback word leaves during the next frame only
      #10;
      rb_data = 16'h3C5A;
      rb_load = 1'b1;
      #10;
      rb_load = 1'b0;
      #20;
      send_frame(16, 64'h0F0F, 1'b0, 1'b1, 16'h3C5A);
      check(sdo_err == 0, "R9 readback stream", 64'(sdo_err), 0);
      check(word === 16'h0F0F, "R9 word with readback", 64'(word), 64'h0F0F);
      send_frame(16, 64'hFFFF, 1'b0, 1'b0, '0);
      check(sdo_err == 0, "R9 readback gone next frame", 64'(sdo_err), 0);
      check(vld_cnt == 1, "R3 strobe after readback", 64'(vld_cnt), 1);

      // R1 reset in the middle of a frame clears the word and register
      sync_n = 1'b0;
      #20;
      for (int i = 0; i < 8; i++) begin
         din = 1'b1;
         #10 sclk = 1'b1;
         #20 sclk = 1'b0;
         #10;
      end
      vld_cnt = 0;
      rst_n = 1'b0;
      #20;
      sync_n = 1'b1;
      #20;
      rst_n = 1'b1;
      #100;
      check(vld_cnt == 0, "R1 no strobe on reset", 64'(vld_cnt), 0);
      check(word === '0, "R1 word after reset", 64'(word), 0);
      exp_sh = '0;
      send_frame(16, 64'h00F0, 1'b0, 1'b0, '0);
      check(sdo_err == 0, "R1/R8 zero register after reset", 64'(sdo_err), 0);
      check(word === 16'h00F0, "R2 word after reset", 64'(word), 64'h00F0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule